// File: doc/BRIEF.md
# SEC-DED Protected Memory Wrapper

This block holds a banked word memory in which every 32-bit data word is stored together with seven check bits: six Hamming bits plus one overall parity bit, making a 39-bit stored word. Reads pass through a decoder. The decoder silently repairs any single flipped bit and flags any two flipped bits as uncorrectable. Requesters may write a full word, a half-word or single bytes, selected by byte enables. A write narrower than a word is turned internally into read, correct, merge, re-encode and store. This takes one extra cycle, during which the request port is held off.

Each bank has a protection switch, and all banks are protected after reset. A bank with protection off returns its stored data bits untouched and raises no flags. Its writes are still encoded in full, so the bank can be switched back on at any time. Corrected and uncorrectable events come out as per-access pulses. A fault output repeats the uncorrectable event only while fault reporting is enabled. A status register keeps the address and syndrome of the first uncorrectable error until it is cleared. A bit-flip port lets a test corrupt stored bits on purpose.

Top module: `ecc_mem_wrap`

## Requirements
- R1: After reset, all banks are protected, `req_ready` is 1, and `rsp_valid`, `sbe_evt`, `dbe_evt`, `dbe_fault` and `stat_valid` are 0.
- R2: A read accepted at a clock edge (`req_valid` with `req_ready` high) gives `rsp_valid` and the stored word on `rsp_rdata` in the following cycle. A full write (`req_be` = 4'hF) completes without a stall.
- R3: In a protected bank, flipping any single one of the 39 stored bits does not change the returned data, and `sbe_evt` pulses in the response cycle with `dbe_evt` low.
- R4: In a protected bank, two flipped stored bits raise `dbe_evt` in the response cycle. `dbe_fault` follows it only while `fault_en` is 1.
- R5: A write with byte enables that are neither 0 nor all ones replaces only the enabled bytes. Bit k of `req_be` selects data bits 8k+7..8k. `req_ready` is 0 for exactly the one cycle after the write is accepted.
- R6: A partial write over a word with one flipped bit corrects the old word before merging, pulses `sbe_evt` in the merge cycle, and stores a clean word.
- R7: A partial write that finds two flipped bits is abandoned. The stored word stays as it was, so a later read still reports `dbe_evt`, and `dbe_evt` pulses in the merge cycle.
- R8: In a bank with protection off, reads return the stored data bits raw, with no flags. Stored bit index 2 carries data bit 0.
- R9: Writes into an unprotected bank still store correct check bits, so once protection is turned back on the word reads cleanly and single flips are corrected.
- R10: The status register records the address and the 7-bit syndrome of the first uncorrectable error and ignores later ones. Stored bit index i (0..37) is code position i+1 and index 38 is overall parity. For two flips the syndrome is {1'b0, (i+1)^(j+1)}. A one on `stat_clr` clears the register; if a new uncorrectable error arrives in the same cycle, the new error is recorded.
- R11: A write with `req_be` = 0 stores nothing and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address; upper bit selects the bank |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sbe_evt | output | 1 | Corrected single-bit event pulse |
| dbe_evt | output | 1 | Uncorrectable double-bit event pulse |
| dbe_fault | output | 1 | Gated uncorrectable fault |
| fault_en | input | 1 | Enables `dbe_fault` |
| cfg_we | input | 1 | Loads the per-bank protection mask |
| cfg_prot | input | 2 | Protection enable per bank |
| stat_clr | input | 1 | Write-one-to-clear for status |
| stat_valid | output | 1 | Status holds an error |
| stat_addr | output | 5 | Address of first uncorrectable error |
| stat_syn | output | 7 | Syndrome of that error |
| inj_en | input | 1 | Apply the bit-flip mask |
| inj_addr | input | 5 | Word to corrupt |
| inj_mask | input | 39 | Stored bits to flip |

## Verification
Two pairs of functions can fall in the same cycle. The first is a status clear together with a new uncorrectable error. The bench reads a double-flipped word while pulsing `stat_clr` in the response cycle, and expects the status to come back valid with the new address and syndrome rather than cleared. The second is the correction of a single flip together with the byte merge of a partial write. The bench corrupts a word, writes one byte to it, and expects a corrected-event pulse in the merge cycle, then a clean read of the merged word.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DW = 32;
  localparam int CW = 39;
  localparam int SW = 7;

  // positions 1..38 that are not powers of two carry data, in order
  function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    int k;
    logic par;
    w = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[k];
        k++;
      end
    end
    for (int b = 0; b < 6; b++) begin
      par = 1'b0;
      for (int p = 1; p <= 38; p++)
        if (((p >> b) & 1) == 1 && (p & (p - 1)) != 0) par ^= w[p-1];
      w[(1 << b) - 1] = par;
    end
    w[38] = ^w[37:0];
    return w;
  endfunction

  function automatic logic [DW-1:0] ecc_extract(input logic [CW-1:0] w);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p-1];
        k++;
      end
    end
    return d;
  endfunction

  // {overall parity mismatch, Hamming position}
  function automatic logic [SW-1:0] ecc_syndrome(input logic [CW-1:0] w);
    logic [5:0] s;
    s = '0;
    for (int p = 1; p <= 38; p++)
      if (w[p-1]) s ^= 6'(p);
    return {^w, s};
  endfunction
endpackage

// File: rtl/ecc_store.sv
module ecc_store #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [ecc_pkg::CW-1:0] wword,
  input  logic                   inj_en,
  input  logic [AW-1:0]          inj_addr,
  input  logic [ecc_pkg::CW-1:0] inj_mask,
  input  logic [AW-1:0]          raddr,
  output logic [ecc_pkg::CW-1:0] rword
);
  logic [ecc_pkg::CW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (inj_en) cells[inj_addr] <= cells[inj_addr] ^ inj_mask;
    if (we) cells[waddr] <= wword;
  end

  assign rword = cells[raddr];
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  logic [CW-1:0] word,
  input  logic          prot,
  output logic [DW-1:0] data,
  output logic          sbe,
  output logic          dbe,
  output logic [SW-1:0] syn
);
  logic [CW-1:0] fixed;
  logic [5:0]    pos;
  logic          ov;

  assign syn = ecc_syndrome(word);
  assign pos = syn[5:0];
  assign ov  = syn[6];

  always_comb begin
    fixed = word;
    if (ov && pos != 6'd0 && pos <= 6'd38) fixed[pos - 6'd1] = ~word[pos - 6'd1];
  end

  assign data = ecc_extract(prot ? fixed : word);
  assign sbe  = prot & ov & (pos <= 6'd38);
  assign dbe  = prot & ((!ov && pos != 6'd0) || (ov && pos > 6'd38));
endmodule

// File: rtl/ecc_status.sv
module ecc_status #(
  parameter int AW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt,
  input  logic [AW-1:0]          addr,
  input  logic [ecc_pkg::SW-1:0] syn,
  input  logic                   clr,
  output logic                   valid,
  output logic [AW-1:0]          addr_q,
  output logic [ecc_pkg::SW-1:0] syn_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (evt && (!valid || clr)) begin
      valid  <= 1'b1;
      addr_q <= addr;
      syn_q  <= syn;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_mem_wrap.sv
module ecc_mem_wrap
  import ecc_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WORDS = 16,
  localparam int DEPTH = NUM_BANKS * BANK_WORDS,
  localparam int AW    = $clog2(DEPTH),
  localparam int IW    = $clog2(BANK_WORDS),
  localparam int NBE   = DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [NBE-1:0]       req_be,
  input  logic [DW-1:0]        req_wdata,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 sbe_evt,
  output logic                 dbe_evt,
  output logic                 dbe_fault,
  input  logic                 fault_en,
  input  logic                 cfg_we,
  input  logic [NUM_BANKS-1:0] cfg_prot,
  input  logic                 stat_clr,
  output logic                 stat_valid,
  output logic [AW-1:0]        stat_addr,
  output logic [SW-1:0]        stat_syn,
  input  logic                 inj_en,
  input  logic [AW-1:0]        inj_addr,
  input  logic [CW-1:0]        inj_mask
);
  logic [NUM_BANKS-1:0] prot_q;
  logic                 rd_v_q, rmw_q;
  logic [AW-1:0]        cap_addr;
  logic [NBE-1:0]       cap_be;
  logic [DW-1:0]        cap_wd;
  logic [CW-1:0]        cap_word, rword, wword;
  logic                 accept, full_wr, part_wr, rmw_wr, mem_we, live, cap_prot;
  logic [AW-1:0]        waddr;
  logic [DW-1:0]        dec_data, merged;
  logic                 dec_sbe, dec_dbe;
  logic [SW-1:0]        dec_syn;

  assign req_ready = !rmw_q;
  assign accept    = req_valid & req_ready;
  assign full_wr   = accept & req_write & (req_be == '1);
  assign part_wr   = accept & req_write & (req_be != '0) & (req_be != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q   <= '1;
      rd_v_q   <= 1'b0;
      rmw_q    <= 1'b0;
      cap_addr <= '0;
      cap_be   <= '0;
      cap_wd   <= '0;
      cap_word <= '0;
    end else begin
      if (cfg_we) prot_q <= cfg_prot;
      rd_v_q <= accept & !req_write;
      rmw_q  <= part_wr;
      if (accept) begin
        cap_addr <= req_addr;
        cap_be   <= req_be;
        cap_wd   <= req_wdata;
        cap_word <= rword;
      end
    end
  end

  assign cap_prot = prot_q[cap_addr[AW-1:IW]];

  ecc_dec u_dec (
    .word(cap_word), .prot(cap_prot), .data(dec_data),
    .sbe(dec_sbe), .dbe(dec_dbe), .syn(dec_syn)
  );

  for (genvar b = 0; b < NBE; b++) begin : g_lane
    assign merged[8*b +: 8] = cap_be[b] ? cap_wd[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign live      = rd_v_q | rmw_q;
  assign sbe_evt   = live & dec_sbe;
  assign dbe_evt   = live & dec_dbe;
  assign dbe_fault = dbe_evt & fault_en;
  assign rsp_valid = rd_v_q;
  assign rsp_rdata = dec_data;

  assign rmw_wr = rmw_q & !dec_dbe;
  assign mem_we = full_wr | rmw_wr;
  assign waddr  = rmw_q ? cap_addr : req_addr;
  assign wword  = ecc_encode(rmw_q ? merged : req_wdata);

  ecc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wword(wword),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .raddr(req_addr), .rword(rword)
  );

  ecc_status #(.AW(AW)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(dbe_evt), .addr(cap_addr), .syn(dec_syn),
    .clr(stat_clr), .valid(stat_valid), .addr_q(stat_addr), .syn_q(stat_syn)
  );
endmodule

// File: rtl/ecc_mem_chk.sv
module ecc_mem_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [3:0]    req_be,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          sbe_evt,
  input logic          dbe_evt,
  input logic          dbe_fault,
  input logic          stat_clr,
  input logic          stat_valid,
  input logic [AW-1:0] stat_addr,
  input logic [6:0]    stat_syn
);
  a_r5_rmw_stall: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && req_be != 4'h0 && req_be != 4'hF |=> !req_ready);

  a_r5_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sbe_evt && dbe_evt));

  a_r4_fault_records_status: assert property (@(posedge clk) disable iff (!rst_n)
    dbe_fault |=> stat_valid);

  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_clr |=> stat_valid && $stable(stat_addr) && $stable(stat_syn));
endmodule

bind ecc_mem_wrap ecc_mem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_be(req_be), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sbe_evt(sbe_evt), .dbe_evt(dbe_evt), .dbe_fault(dbe_fault),
  .stat_clr(stat_clr), .stat_valid(stat_valid), .stat_addr(stat_addr),
  .stat_syn(stat_syn)
);

// File: tb/tb_ecc_mem_wrap.sv
module tb_ecc_mem_wrap;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [4:0]  a;
    logic [31:0] d;
    logic [5:0]  f0;
    logic [5:0]  f1;
    logic        es;
    logic        ed;
  } vec_t;

  // flip index 63 = no flip
  localparam vec_t VEC [6] = '{
    '{5'd3,  32'hA5A5_1234, 6'd63, 6'd63, 1'b0, 1'b0},
    '{5'd7,  32'hDEAD_BEEF, 6'd5,  6'd63, 1'b1, 1'b0},
    '{5'd18, 32'h0000_0001, 6'd38, 6'd63, 1'b1, 1'b0},
    '{5'd20, 32'hFFFF_FFFF, 6'd0,  6'd63, 1'b1, 1'b0},
    '{5'd9,  32'h1357_9BDF, 6'd2,  6'd10, 1'b0, 1'b1},
    '{5'd31, 32'h0000_0000, 6'd37, 6'd63, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, sbe_evt, dbe_evt, dbe_fault;
  logic [31:0] rsp_rdata;
  logic fault_en = 1'b1, cfg_we = 1'b0, stat_clr = 1'b0, inj_en = 1'b0;
  logic [1:0] cfg_prot = 2'b11;
  logic stat_valid;
  logic [4:0] stat_addr, inj_addr = '0;
  logic [6:0] stat_syn;
  logic [38:0] inj_mask = '0;

  int total = 0, bad = 0;
  logic [31:0] r_data;
  logic r_vld, r_sbe, r_dbe, r_fault, m_ready, m_sbe, m_dbe, m_ready2;

  ecc_mem_wrap dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [38:0] act, input logic [38:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    m_ready = req_ready; m_sbe = sbe_evt; m_dbe = dbe_evt;
    @(negedge clk);
    m_ready2 = req_ready;
  endtask

  task automatic rd(input logic [4:0] a, input logic clr);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0; stat_clr = clr;
    r_vld = rsp_valid; r_data = rsp_rdata; r_sbe = sbe_evt; r_dbe = dbe_evt; r_fault = dbe_fault;
    @(negedge clk);
    stat_clr = 0;
  endtask

  task automatic flip(input logic [4:0] a, input logic [38:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_en = 0; inj_mask = '0;
  endtask

  task automatic set_prot(input logic [1:0] p);
    @(negedge clk);
    cfg_we = 1; cfg_prot = p;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 events", {sbe_evt, dbe_evt, dbe_fault}, 0);
    chk("R1 stat_valid", stat_valid, 0);

    // table walk: R2 R3 R4
    foreach (VEC[i]) begin
      logic [38:0] m;
      m = '0;
      if (VEC[i].f0 != 6'd63) m[VEC[i].f0] = 1'b1;
      if (VEC[i].f1 != 6'd63) m[VEC[i].f1] = 1'b1;
      wr(VEC[i].a, 4'hF, VEC[i].d);
      chk("R2 full write no stall", m_ready, 1);
      if (m != '0) flip(VEC[i].a, m);
      rd(VEC[i].a, 1'b0);
      chk("R2 rsp_valid", r_vld, 1);
      if (!VEC[i].ed) chk("R3 data", r_data, VEC[i].d);
      chk("R3 sbe", r_sbe, VEC[i].es);
      chk("R4 dbe", r_dbe, VEC[i].ed);
      chk("R4 fault", r_fault, VEC[i].ed);
    end

    // R10 first error recorded: addr 9, flips 2,10 -> syn 3^11
    chk("R10 stat_valid", stat_valid, 1);
    chk("R10 stat_addr", stat_addr, 9);
    chk("R10 stat_syn", stat_syn, 7'd8);

    // R4 gated fault
    fault_en = 0;
    rd(5'd9, 1'b0);
    chk("R4 dbe ungated", r_dbe, 1);
    chk("R4 fault gated off", r_fault, 0);
    fault_en = 1;

    // R10 later error does not overwrite
    wr(5'd12, 4'hF, 32'h2468_ACE0);
    flip(5'd12, 39'h11);
    rd(5'd12, 1'b0);
    chk("R10 second dbe", r_dbe, 1);
    chk("R10 first kept", stat_addr, 9);

    // R10 clear alone
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    chk("R10 cleared", stat_valid, 0);

    // R10 clear and new error in same cycle
    rd(5'd12, 1'b0);
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    rd(5'd12, 1'b1);
    chk("R10 same-cycle valid", stat_valid, 1);
    chk("R10 same-cycle addr", stat_addr, 12);
    chk("R10 same-cycle syn", stat_syn, 7'd4);

    // R7 aborted partial write on double error
    wr(5'd12, 4'h1, 32'h0000_00FF);
    chk("R7 stall", m_ready, 0);
    chk("R7 merge dbe", m_dbe, 1);
    rd(5'd12, 1'b0);
    chk("R7 word untouched", r_dbe, 1);

    // R5 partial merges
    wr(5'd4, 4'hF, 32'h1122_3344);
    wr(5'd4, 4'b0010, 32'h0000_AB00);
    chk("R5 stall cycle", m_ready, 0);
    chk("R5 stall ends", m_ready2, 1);
    rd(5'd4, 1'b0);
    chk("R5 byte merge", r_data, 32'h1122_AB44);
    wr(5'd4, 4'b1100, 32'hCAFE_0000);
    rd(5'd4, 1'b0);
    chk("R5 half merge", r_data, 32'hCAFE_AB44);

    // R6 partial write over a single flip
    flip(5'd4, 39'h1 << 20);
    wr(5'd4, 4'b0001, 32'h0000_0077);
    chk("R6 merge sbe", m_sbe, 1);
    rd(5'd4, 1'b0);
    chk("R6 data", r_data, 32'hCAFE_AB77);
    chk("R6 clean after", {r_sbe, r_dbe}, 0);

    // R11 empty byte enables
    wr(5'd4, 4'h0, 32'h0);
    chk("R11 no stall", m_ready, 1);
    rd(5'd4, 1'b0);
    chk("R11 unchanged", r_data, 32'hCAFE_AB77);

    // R8 bank 1 off: addr 20 has a flip at index 0
    set_prot(2'b01);
    rd(5'd20, 1'b0);
    chk("R8 raw data", r_data, 32'hFFFF_FFFF);
    chk("R8 no flags", {r_sbe, r_dbe}, 0);
    flip(5'd20, 39'h4);
    rd(5'd20, 1'b0);
    chk("R8 raw flipped", r_data, 32'hFFFF_FFFE);
    chk("R8 no flags two flips", {r_sbe, r_dbe}, 0);

    // R9 write while off, read after re-enable
    wr(5'd21, 4'hF, 32'h0BAD_F00D);
    set_prot(2'b11);
    rd(5'd21, 1'b0);
    chk("R9 data", r_data, 32'h0BAD_F00D);
    chk("R9 clean", {r_sbe, r_dbe}, 0);
    flip(5'd21, 39'h1 << 15);
    rd(5'd21, 1'b0);
    chk("R9 corrected", r_data, 32'h0BAD_F00D);
    chk("R9 sbe", r_sbe, 1);

    finish_run();
  end
endmodule